// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the 64-byte type-0 configuration header of one PCI function. A simple register bus reaches it. A request carries an offset, an access size in bytes (1, 2 or 4) and write data. The response comes back exactly one cycle later, with read data and an error flag. At reset, the identity fields and the default field values come from parameters.

There are six base address registers. Software sizes each one by writing all ones and reading back the size mask. Writing an address relocates the register onto a fixed I/O or memory space base. For each register the block drives the decoded base address and an enable, which the surrounding fabric uses for address routing. A single pulse output tells the fabric that a decoded range has moved. The expansion ROM register has its own probe value. Each other field has a writability rule that depends on the access size.

The size of each base address register is a parameter. It must be zero, meaning unimplemented, or a power of two. Any other value stops elaboration.

Top module: `pci_cfg_space`

## Requirements
- R1: After synchronous active-high reset, the fields read back their parameter values, every decoded base is zero, every enable is low, and `range_changed` is low.
- R2: Every request cycle with `req_valid` high gives exactly one `rsp_valid` cycle on the following clock. No `rsp_valid` appears without a request.
- R3: A read returns `req_size` bytes starting at `req_offset`, least significant byte first in bits 7:0. Unused upper bytes read as zero. A legal read never changes any state.
- R4: Some accesses are illegal: a size other than 1, 2 or 4; an access that reaches byte 0x40 or beyond; or a write to an offset that has no rule below. An illegal access sets `rsp_err` together with `rsp_valid`, returns zero data and changes no state.
- R5: Byte writes take their data from bits 7:0. They update interrupt line (0x3C), cache line size (0x0C) and latency timer (0x0D). Byte writes to revision (0x08), class (0x0B), interrupt pin (0x3D), minimum grant (0x3E) and maximum latency (0x3F) have no effect and raise no error.
- R6: A halfword write (data in bits 15:0) or a dword write at offset 0x04 replaces the 16-bit command field. The status field at 0x06 is not changed. A halfword write at 0x06 has no effect and raises no error.
- R7: A dword write of 0xFFFFFFFF to a base address register (offsets 0x10 to 0x24, step 4) stores ~(size-1) in its address bits, so the next read returns the size mask. The decoded base does not change.
- R8: Bit 0 of the old register value selects the register type: 1 means I/O, 0 means memory. Every write keeps the low 2 bits of an I/O register or the low 4 bits of a memory register, and clears those bits from the written address.
- R9: Any other written value whose masked address bits are non-zero sets the decoded base to those bits plus the I/O or memory space base. This raises the enable and pulses `range_changed` for one cycle with the response.
- R10: A written value whose masked address bits are zero clears the stored address bits. The decoded base, the enable and `range_changed` are left as they were.
- R11: A base address register with size zero always reads zero, ignores writes, never enables and never pulses `range_changed`.
- R12: A dword write of 0xFFFFFFFE to the expansion ROM register (0x30) makes it read 0xFFFFFFFF. Any other dword value is stored as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 for write, 0 for read |
| req_offset | input | 8 | Byte offset into the header |
| req_size | input | 3 | Access size in bytes |
| req_wdata | input | 32 | Write data, right-aligned |
| rsp_valid | output | 1 | Response, one cycle after the request |
| rsp_err | output | 1 | Illegal access flag |
| rsp_rdata | output | 32 | Read data, right-aligned |
| bar_base | output | 192 | Decoded base per register, register i at bits 32i+31:32i |
| bar_en | output | 6 | Range enable per register |
| range_changed | output | 1 | One-cycle pulse when a decoded base moves |

## Verification
A wrong stored field or decode shows up on the first read of the affected offset, one cycle after the request. A wrong type-bit mask or space base shows up in the same cycle as the response, because the decoded base outputs and the `range_changed` pulse are registered on the same edge as `rsp_valid`. A write that leaks through an illegal or ignored access stays hidden until the field is read back. The directed scenarios therefore read back each field they might have disturbed.

// File: rtl/pci_cfg_pkg.sv
package pci_cfg_pkg;

    localparam int BAR_COUNT  = 6;
    localparam int HDR_BYTES  = 64;
    localparam int HDR_DWORDS = HDR_BYTES / 4;
    localparam int OFS_W      = 8;
    localparam int DATA_W     = 32;

    localparam logic [OFS_W-1:0] OFS_COMMAND    = 8'h04;
    localparam logic [OFS_W-1:0] OFS_STATUS     = 8'h06;
    localparam logic [OFS_W-1:0] OFS_REVISION   = 8'h08;
    localparam logic [OFS_W-1:0] OFS_CLASS      = 8'h0B;
    localparam logic [OFS_W-1:0] OFS_CACHE_LINE = 8'h0C;
    localparam logic [OFS_W-1:0] OFS_LAT_TIMER  = 8'h0D;
    localparam logic [OFS_W-1:0] OFS_BAR_FIRST  = 8'h10;
    localparam logic [OFS_W-1:0] OFS_ROM        = 8'h30;
    localparam logic [OFS_W-1:0] OFS_INT_LINE   = 8'h3C;
    localparam logic [OFS_W-1:0] OFS_INT_PIN    = 8'h3D;
    localparam logic [OFS_W-1:0] OFS_MIN_GNT    = 8'h3E;
    localparam logic [OFS_W-1:0] OFS_MAX_LAT    = 8'h3F;

    localparam logic [DATA_W-1:0] IO_TYPE_MASK  = 32'h0000_0003;
    localparam logic [DATA_W-1:0] MEM_TYPE_MASK = 32'h0000_000F;
    localparam logic [DATA_W-1:0] BAR_PROBE     = 32'hFFFF_FFFF;
    localparam logic [DATA_W-1:0] ROM_PROBE     = 32'hFFFF_FFFE;

    typedef enum logic [2:0] {
        ACC_BYTE = 3'd1,
        ACC_HALF = 3'd2,
        ACC_WORD = 3'd4
    } acc_size_e;

    typedef struct packed {
        logic              write;
        logic [OFS_W-1:0]  offset;
        logic [2:0]        size;
        logic [DATA_W-1:0] wdata;
    } cfg_req_t;

    typedef struct packed {
        logic                 err;
        logic                 rd;
        logic                 wr_command;
        logic                 wr_int_line;
        logic                 wr_cache_line;
        logic                 wr_lat_timer;
        logic                 wr_rom;
        logic [BAR_COUNT-1:0] wr_bar;
    } cfg_dec_t;

    function automatic logic [DATA_W-1:0] bar_type_mask(input logic is_io);
        return is_io ? IO_TYPE_MASK : MEM_TYPE_MASK;
    endfunction

    function automatic logic [DATA_W-1:0] rom_next(input logic [DATA_W-1:0] wdata);
        return (wdata == ROM_PROBE) ? BAR_PROBE : wdata;
    endfunction

endpackage

// File: rtl/pci_cfg_decode.sv
module pci_cfg_decode
    import pci_cfg_pkg::*;
(
    input  logic     req_valid,
    input  cfg_req_t req,
    output cfg_dec_t dec
);

    logic                 size_ok;
    logic                 in_hdr;
    logic [OFS_W:0]       end_ofs;
    logic [BAR_COUNT-1:0] bar_hit;

    always_comb begin
        size_ok = (req.size == ACC_BYTE) || (req.size == ACC_HALF) || (req.size == ACC_WORD);
        end_ofs = {1'b0, req.offset} + {{(OFS_W-2){1'b0}}, req.size};
        in_hdr  = end_ofs <= (OFS_W+1)'(HDR_BYTES);
        for (int i = 0; i < BAR_COUNT; i++) begin
            bar_hit[i] = (req.offset == OFS_BAR_FIRST + OFS_W'(4 * i));
        end
    end

    always_comb begin
        dec = '0;
        if (req_valid) begin
            if (!size_ok || !in_hdr) begin
                dec.err = 1'b1;
            end else if (!req.write) begin
                dec.rd = 1'b1;
            end else begin
                case (acc_size_e'(req.size))
                    ACC_BYTE: begin
                        case (req.offset)
                            OFS_INT_LINE:   dec.wr_int_line   = 1'b1;
                            OFS_CACHE_LINE: dec.wr_cache_line = 1'b1;
                            OFS_LAT_TIMER:  dec.wr_lat_timer  = 1'b1;
                            OFS_INT_PIN, OFS_MIN_GNT, OFS_MAX_LAT,
                            OFS_CLASS, OFS_REVISION: ;
                            default:        dec.err = 1'b1;
                        endcase
                    end
                    ACC_HALF: begin
                        case (req.offset)
                            OFS_COMMAND: dec.wr_command = 1'b1;
                            OFS_STATUS:  ;
                            default:     dec.err = 1'b1;
                        endcase
                    end
                    default: begin
                        if (req.offset == OFS_COMMAND) begin
                            dec.wr_command = 1'b1;
                        end else if (req.offset == OFS_ROM) begin
                            dec.wr_rom = 1'b1;
                        end else if (|bar_hit) begin
                            dec.wr_bar = bar_hit;
                        end else begin
                            dec.err = 1'b1;
                        end
                    end
                endcase
            end
        end
    end

endmodule

// File: rtl/pci_cfg_bar.sv
module pci_cfg_bar
    import pci_cfg_pkg::*;
#(
    parameter logic [31:0] SIZE     = 32'h0000_1000,
    parameter logic [31:0] INIT     = 32'h0000_0000,
    parameter logic [31:0] IO_BASE  = 32'h0100_0000,
    parameter logic [31:0] MEM_BASE = 32'h4000_0000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] bar_value,
    output logic [DATA_W-1:0] base,
    output logic              en,
    output logic              moved
);

    localparam bit          IMPLEMENTED = (SIZE != 32'd0);
    localparam logic [31:0] RESET_VALUE = IMPLEMENTED ? INIT : 32'd0;
    localparam logic [31:0] SIZE_MASK   = ~(SIZE - 32'd1);

    generate
        if ((SIZE & (SIZE - 32'd1)) != 32'd0) begin : g_bad_size
            $error("base address register size must be zero or a power of two");
        end
    endgenerate

    logic [DATA_W-1:0] bar_q;
    logic [DATA_W-1:0] base_q;
    logic              moved_q;
    logic              wr_eff;
    logic              old_io;
    logic              probe;
    logic [DATA_W-1:0] keep_mask;
    logic [DATA_W-1:0] addr_bits;
    logic              relocate;

    always_comb begin
        wr_eff    = wr_en && IMPLEMENTED;
        old_io    = bar_q[0];
        keep_mask = bar_type_mask(old_io);
        probe     = (wdata == BAR_PROBE);
        addr_bits = probe ? SIZE_MASK : (wdata & ~keep_mask);
        relocate  = wr_eff && !probe && (addr_bits != '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bar_q   <= RESET_VALUE;
            base_q  <= '0;
            moved_q <= 1'b0;
        end else begin
            moved_q <= relocate;
            if (wr_eff) begin
                bar_q <= (addr_bits & ~keep_mask) | (bar_q & keep_mask);
            end
            if (relocate) begin
                base_q <= addr_bits + (old_io ? IO_BASE : MEM_BASE);
            end
        end
    end

    assign bar_value = bar_q;
    assign base      = base_q;
    assign en        = (base_q != '0);
    assign moved     = moved_q;

endmodule

// File: rtl/pci_cfg_rdmux.sv
module pci_cfg_rdmux
    import pci_cfg_pkg::*;
(
    input  logic [HDR_BYTES*8-1:0] image,
    input  logic [OFS_W-1:0]       offset,
    input  logic [2:0]             size,
    output logic [DATA_W-1:0]      data
);

    always_comb begin
        data = '0;
        for (int j = 0; j < 4; j++) begin
            if ((j < int'(size)) && (int'(offset) + j < HDR_BYTES)) begin
                data[8*j +: 8] = image[8*(int'(offset) + j) +: 8];
            end
        end
    end

endmodule

// File: rtl/pci_cfg_space.sv
module pci_cfg_space
    import pci_cfg_pkg::*;
#(
    parameter logic [15:0]            VENDOR_ID     = 16'hA5C3,
    parameter logic [15:0]            DEVICE_ID     = 16'h7E21,
    parameter logic [31:0]            CLASS_REV     = 32'h0200_0003,
    parameter logic [7:0]             HEADER_TYPE   = 8'h00,
    parameter logic [7:0]             BIST_INIT     = 8'h00,
    parameter logic [15:0]            COMMAND_INIT  = 16'h0000,
    parameter logic [15:0]            STATUS_VALUE  = 16'h0010,
    parameter logic [7:0]             CACHE_LINE    = 8'h00,
    parameter logic [7:0]             LAT_TIMER     = 8'h00,
    parameter logic [31:0]            CIS_POINTER   = 32'h0000_0000,
    parameter logic [15:0]            SUBSYS_VENDOR = 16'hA5C3,
    parameter logic [15:0]            SUBSYS_ID     = 16'h0011,
    parameter logic [31:0]            ROM_INIT      = 32'h0000_0000,
    parameter logic [7:0]             INT_LINE      = 8'h0B,
    parameter logic [7:0]             INT_PIN       = 8'h01,
    parameter logic [7:0]             MIN_GNT       = 8'h04,
    parameter logic [7:0]             MAX_LAT       = 8'h08,
    parameter logic [32*BAR_COUNT-1:0] BAR_SIZES    = {32'd0, 32'd0, 32'd0,
                                                       32'h0010_0000, 32'h0000_1000, 32'h0000_0100},
    parameter logic [32*BAR_COUNT-1:0] BAR_INITS    = {32'd0, 32'd0, 32'd0,
                                                       32'h0000_0008, 32'h0000_0000, 32'h0000_0001},
    parameter logic [31:0]            IO_SPACE_BASE  = 32'h0100_0000,
    parameter logic [31:0]            MEM_SPACE_BASE = 32'h4000_0000
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        req_valid,
    input  logic                        req_write,
    input  logic [OFS_W-1:0]            req_offset,
    input  logic [2:0]                  req_size,
    input  logic [DATA_W-1:0]           req_wdata,
    output logic                        rsp_valid,
    output logic                        rsp_err,
    output logic [DATA_W-1:0]           rsp_rdata,
    output logic [32*BAR_COUNT-1:0]     bar_base,
    output logic [BAR_COUNT-1:0]        bar_en,
    output logic                        range_changed
);

    cfg_req_t req;
    cfg_dec_t dec;

    assign req = '{write: req_write, offset: req_offset, size: req_size, wdata: req_wdata};

    pci_cfg_decode i_decode (
        .req_valid (req_valid),
        .req       (req),
        .dec       (dec)
    );

    logic [15:0]       command_q;
    logic [7:0]        int_line_q;
    logic [7:0]        cache_line_q;
    logic [7:0]        lat_timer_q;
    logic [DATA_W-1:0] rom_q;

    logic [DATA_W-1:0]      bar_value [BAR_COUNT];
    logic [BAR_COUNT-1:0]   bar_moved;

    genvar gi;
    generate
        for (gi = 0; gi < BAR_COUNT; gi++) begin : g_bar
            pci_cfg_bar #(
                .SIZE     (BAR_SIZES[32*gi +: 32]),
                .INIT     (BAR_INITS[32*gi +: 32]),
                .IO_BASE  (IO_SPACE_BASE),
                .MEM_BASE (MEM_SPACE_BASE)
            ) i_bar (
                .clk       (clk),
                .rst       (rst),
                .wr_en     (dec.wr_bar[gi]),
                .wdata     (req_wdata),
                .bar_value (bar_value[gi]),
                .base      (bar_base[32*gi +: 32]),
                .en        (bar_en[gi]),
                .moved     (bar_moved[gi])
            );
        end
    endgenerate

    logic [HDR_BYTES*8-1:0] image;

    always_comb begin
        image            = '0;
        image[0*32 +: 32] = {DEVICE_ID, VENDOR_ID};
        image[1*32 +: 32] = {STATUS_VALUE, command_q};
        image[2*32 +: 32] = CLASS_REV;
        image[3*32 +: 32] = {BIST_INIT, HEADER_TYPE, lat_timer_q, cache_line_q};
        for (int i = 0; i < BAR_COUNT; i++) begin
            image[(4 + i)*32 +: 32] = bar_value[i];
        end
        image[10*32 +: 32] = CIS_POINTER;
        image[11*32 +: 32] = {SUBSYS_ID, SUBSYS_VENDOR};
        image[12*32 +: 32] = rom_q;
        image[15*32 +: 32] = {MAX_LAT, MIN_GNT, INT_PIN, int_line_q};
    end

    logic [DATA_W-1:0] rd_word;

    pci_cfg_rdmux i_rdmux (
        .image  (image),
        .offset (req_offset),
        .size   (req_size),
        .data   (rd_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            command_q    <= COMMAND_INIT;
            int_line_q   <= INT_LINE;
            cache_line_q <= CACHE_LINE;
            lat_timer_q  <= LAT_TIMER;
            rom_q        <= ROM_INIT;
            rsp_valid    <= 1'b0;
            rsp_err      <= 1'b0;
            rsp_rdata    <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= dec.err;
            rsp_rdata <= dec.rd ? rd_word : '0;
            if (dec.wr_command)    command_q    <= req_wdata[15:0];
            if (dec.wr_int_line)   int_line_q   <= req_wdata[7:0];
            if (dec.wr_cache_line) cache_line_q <= req_wdata[7:0];
            if (dec.wr_lat_timer)  lat_timer_q  <= req_wdata[7:0];
            if (dec.wr_rom)        rom_q        <= rom_next(req_wdata);
        end
    end

    assign range_changed = |bar_moved;

endmodule

// File: rtl/pci_cfg_checker.sv
module pci_cfg_checker
    import pci_cfg_pkg::*;
#(
    parameter logic [32*BAR_COUNT-1:0] BAR_SIZES = '0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    req_valid,
    input logic                    req_write,
    input logic                    rsp_valid,
    input logic                    rsp_err,
    input logic [32*BAR_COUNT-1:0] bar_base,
    input logic [BAR_COUNT-1:0]    bar_en,
    input logic                    range_changed
);

    assert_rsp_follows_R2: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid);

    assert_no_spurious_rsp_R2: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid);

    assert_err_keeps_bases_R4: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> (rsp_valid && $stable(bar_base)));

    assert_read_keeps_bases_R3: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && !$past(req_write)) |-> $stable(bar_base));

    assert_base_move_pulses_R9: assert property (@(posedge clk) disable iff (rst)
        !$stable(bar_base) |-> range_changed);

    assert_pulse_with_rsp_R9: assert property (@(posedge clk) disable iff (rst)
        range_changed |-> (rsp_valid && !rsp_err));

    genvar gi;
    generate
        for (gi = 0; gi < BAR_COUNT; gi++) begin : g_unimpl
            if (BAR_SIZES[32*gi +: 32] == 32'd0) begin : g_zero
                assert_unimpl_disabled_R11: assert property (@(posedge clk) disable iff (rst)
                    !bar_en[gi] && (bar_base[32*gi +: 32] == 32'd0));
            end
        end
    endgenerate

endmodule

bind pci_cfg_space pci_cfg_checker #(.BAR_SIZES(BAR_SIZES)) i_chk (
    .clk           (clk),
    .rst           (rst),
    .req_valid     (req_valid),
    .req_write     (req_write),
    .rsp_valid     (rsp_valid),
    .rsp_err       (rsp_err),
    .bar_base      (bar_base),
    .bar_en        (bar_en),
    .range_changed (range_changed)
);

// File: tb/test_pci_cfg_space.sv
module test_pci_cfg_space;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 20000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         req_valid = 1'b0;
    logic         req_write = 1'b0;
    logic [7:0]   req_offset = '0;
    logic [2:0]   req_size = '0;
    logic [31:0]  req_wdata = '0;
    logic         rsp_valid;
    logic         rsp_err;
    logic [31:0]  rsp_rdata;
    logic [191:0] bar_base;
    logic [5:0]   bar_en;
    logic         range_changed;

    int total = 0;
    int fails = 0;

    logic [31:0] r_data;
    logic        r_err;
    logic        r_chg;

    always #(CLK_PERIOD/2) clk = ~clk;

    pci_cfg_space #(
        .VENDOR_ID     (16'hA5C3),
        .DEVICE_ID     (16'h7E21),
        .CLASS_REV     (32'h0200_0003),
        .STATUS_VALUE  (16'h0010),
        .INT_LINE      (8'h0B),
        .INT_PIN       (8'h01),
        .MIN_GNT       (8'h04),
        .MAX_LAT       (8'h08),
        .BAR_SIZES     ({32'd0, 32'd0, 32'd0, 32'h0010_0000, 32'h0000_1000, 32'h0000_0100}),
        .BAR_INITS     ({32'd0, 32'd0, 32'd0, 32'h0000_0008, 32'h0000_0000, 32'h0000_0001}),
        .IO_SPACE_BASE (32'h0100_0000),
        .MEM_SPACE_BASE(32'h4000_0000)
    ) i_pci_cfg_space (
        .clk           (clk),
        .rst           (rst),
        .req_valid     (req_valid),
        .req_write     (req_write),
        .req_offset    (req_offset),
        .req_size      (req_size),
        .req_wdata     (req_wdata),
        .rsp_valid     (rsp_valid),
        .rsp_err       (rsp_err),
        .rsp_rdata     (rsp_rdata),
        .bar_base      (bar_base),
        .bar_en        (bar_en),
        .range_changed (range_changed)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic access(input logic wr, input logic [7:0] ofs, input logic [2:0] sz,
                          input logic [31:0] wd);
        @(negedge clk);
        req_valid  = 1'b1;
        req_write  = wr;
        req_offset = ofs;
        req_size   = sz;
        req_wdata  = wd;
        @(negedge clk);
        chk("R2 rsp_valid", {31'd0, rsp_valid}, 32'd1);
        r_data = rsp_rdata;
        r_err  = rsp_err;
        r_chg  = range_changed;
        req_valid = 1'b0;
    endtask

    function automatic logic [31:0] base_of(input int i);
        return bar_base[32*i +: 32];
    endfunction

    task automatic t_reset();
        chk("R1 rsp_valid idle", {31'd0, rsp_valid}, 32'd0);
        chk("R1 bar_en", {26'd0, bar_en}, 32'd0);
        chk("R1 bar_base0", base_of(0), 32'd0);
        chk("R1 range_changed", {31'd0, range_changed}, 32'd0);
        access(1'b0, 8'h00, 3'd4, 32'd0);
        chk("R1 id dword", r_data, 32'h7E21_A5C3);
        access(1'b0, 8'h10, 3'd4, 32'd0);
        chk("R1 bar0 init", r_data, 32'h0000_0001);
        access(1'b0, 8'h18, 3'd4, 32'd0);
        chk("R1 bar2 init", r_data, 32'h0000_0008);
    endtask

    task automatic t_reads();
        access(1'b0, 8'h01, 3'd1, 32'd0);
        chk("R3 byte read", r_data, 32'h0000_00A5);
        chk("R3 no err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h02, 3'd2, 32'd0);
        chk("R3 half read", r_data, 32'h0000_7E21);
        access(1'b0, 8'h3C, 3'd4, 32'd0);
        chk("R3 dword 3C", r_data, 32'h0804_010B);
        access(1'b0, 8'h3E, 3'd2, 32'd0);
        chk("R3 half 3E", r_data, 32'h0000_0804);
        access(1'b0, 8'h09, 3'd4, 32'd0);
        chk("R3 unaligned dword", r_data, 32'h0002_0000);
        @(negedge clk);
        chk("R2 single rsp", {31'd0, rsp_valid}, 32'd0);
    endtask

    task automatic t_errors();
        access(1'b0, 8'h40, 3'd1, 32'd0);
        chk("R4 beyond header err", {31'd0, r_err}, 32'd1);
        chk("R4 err data", r_data, 32'd0);
        access(1'b0, 8'h00, 3'd3, 32'd0);
        chk("R4 bad size err", {31'd0, r_err}, 32'd1);
        access(1'b0, 8'h3E, 3'd4, 32'd0);
        chk("R4 crossing err", {31'd0, r_err}, 32'd1);
        access(1'b1, 8'h00, 3'd1, 32'h0000_0055);
        chk("R4 byte ro err", {31'd0, r_err}, 32'd1);
        access(1'b1, 8'h00, 3'd4, 32'h1234_5678);
        chk("R4 dword ro err", {31'd0, r_err}, 32'd1);
        access(1'b1, 8'h3C, 3'd2, 32'h0000_9999);
        chk("R4 half bad ofs err", {31'd0, r_err}, 32'd1);
        access(1'b0, 8'h00, 3'd4, 32'd0);
        chk("R4 id unchanged", r_data, 32'h7E21_A5C3);
        access(1'b0, 8'h3C, 3'd1, 32'd0);
        chk("R4 int line unchanged", r_data, 32'h0000_000B);
    endtask

    task automatic t_bytes();
        access(1'b1, 8'h3C, 3'd1, 32'hFFFF_FF55);
        chk("R5 int line write ok", {31'd0, r_err}, 32'd0);
        access(1'b1, 8'h0C, 3'd1, 32'h0000_0010);
        access(1'b1, 8'h0D, 3'd1, 32'h0000_0020);
        access(1'b1, 8'h3D, 3'd1, 32'h0000_00FF);
        chk("R5 pin ignored no err", {31'd0, r_err}, 32'd0);
        access(1'b1, 8'h08, 3'd1, 32'h0000_00EE);
        chk("R5 revision ignored no err", {31'd0, r_err}, 32'd0);
        access(1'b1, 8'h0B, 3'd1, 32'h0000_00EE);
        access(1'b0, 8'h3C, 3'd4, 32'd0);
        chk("R5 dword 3C", r_data, 32'h0804_0155);
        access(1'b0, 8'h0C, 3'd4, 32'd0);
        chk("R5 cache/latency", r_data, 32'h0000_2010);
        access(1'b0, 8'h08, 3'd4, 32'd0);
        chk("R5 class/rev kept", r_data, 32'h0200_0003);
    endtask

    task automatic t_command();
        access(1'b1, 8'h04, 3'd2, 32'hABCD_0147);
        chk("R6 half cmd ok", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h04, 3'd4, 32'd0);
        chk("R6 half cmd", r_data, 32'h0010_0147);
        access(1'b1, 8'h04, 3'd4, 32'hFFFF_0006);
        access(1'b0, 8'h04, 3'd4, 32'd0);
        chk("R6 dword cmd", r_data, 32'h0010_0006);
        access(1'b1, 8'h06, 3'd2, 32'h0000_BEEF);
        chk("R6 status write no err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h06, 3'd2, 32'd0);
        chk("R6 status kept", r_data, 32'h0000_0010);
    endtask

    task automatic t_sizing();
        access(1'b1, 8'h10, 3'd4, 32'hFFFF_FFFF);
        chk("R7 probe no pulse", {31'd0, r_chg}, 32'd0);
        access(1'b0, 8'h10, 3'd4, 32'd0);
        chk("R7 R8 io size mask", r_data, 32'hFFFF_FF01);
        access(1'b1, 8'h18, 3'd4, 32'hFFFF_FFFF);
        access(1'b0, 8'h18, 3'd4, 32'd0);
        chk("R7 R8 mem size mask", r_data, 32'hFFF0_0008);
        access(1'b1, 8'h14, 3'd4, 32'hFFFF_FFFF);
        access(1'b0, 8'h14, 3'd4, 32'd0);
        chk("R7 bar1 size mask", r_data, 32'hFFFF_F000);
        chk("R7 base unchanged", {26'd0, bar_en}, 32'd0);
    endtask

    task automatic t_reloc();
        access(1'b1, 8'h10, 3'd4, 32'h0000_1202);
        chk("R9 io pulse", {31'd0, r_chg}, 32'd1);
        chk("R9 io base", base_of(0), 32'h0100_1200);
        chk("R9 io enable", {31'd0, bar_en[0]}, 32'd1);
        access(1'b0, 8'h10, 3'd4, 32'd0);
        chk("R8 io type kept", r_data, 32'h0000_1201);
        access(1'b1, 8'h14, 3'd4, 32'h0002_000F);
        chk("R9 mem base", base_of(1), 32'h4002_0000);
        access(1'b0, 8'h14, 3'd4, 32'd0);
        chk("R8 mem low bits", r_data, 32'h0002_0000);
        access(1'b1, 8'h18, 3'd4, 32'h0030_0005);
        chk("R9 bar2 base", base_of(2), 32'h4030_0000);
        access(1'b0, 8'h18, 3'd4, 32'd0);
        chk("R8 prefetch bit kept", r_data, 32'h0030_0008);
        @(negedge clk);
        chk("R9 pulse one cycle", {31'd0, range_changed}, 32'd0);
    endtask

    task automatic t_zero_addr();
        access(1'b1, 8'h14, 3'd4, 32'h0000_0007);
        chk("R10 no pulse", {31'd0, r_chg}, 32'd0);
        chk("R10 base kept", base_of(1), 32'h4002_0000);
        chk("R10 enable kept", {31'd0, bar_en[1]}, 32'd1);
        access(1'b0, 8'h14, 3'd4, 32'd0);
        chk("R10 address cleared", r_data, 32'h0000_0000);
    endtask

    task automatic t_unimpl();
        access(1'b1, 8'h1C, 3'd4, 32'hFFFF_FFFF);
        chk("R11 probe no err", {31'd0, r_err}, 32'd0);
        access(1'b0, 8'h1C, 3'd4, 32'd0);
        chk("R11 reads zero after probe", r_data, 32'd0);
        access(1'b1, 8'h24, 3'd4, 32'h0000_1000);
        chk("R11 no pulse", {31'd0, r_chg}, 32'd0);
        chk("R11 no enable", {29'd0, bar_en[5:3]}, 32'd0);
        chk("R11 base zero", base_of(5), 32'd0);
        access(1'b0, 8'h24, 3'd4, 32'd0);
        chk("R11 reads zero", r_data, 32'd0);
    endtask

    task automatic t_rom();
        access(1'b1, 8'h30, 3'd4, 32'hFFFF_FFFE);
        access(1'b0, 8'h30, 3'd4, 32'd0);
        chk("R12 rom probe", r_data, 32'hFFFF_FFFF);
        access(1'b1, 8'h30, 3'd4, 32'h1234_5678);
        access(1'b0, 8'h30, 3'd4, 32'd0);
        chk("R12 rom store", r_data, 32'h1234_5678);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_reads();
        t_errors();
        t_bytes();
        t_command();
        t_sizing();
        t_reloc();
        t_zero_addr();
        t_unimpl();
        t_rom();
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        total++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule